// File: doc/BRIEF.md
# RMII-to-MII Nibble Bridge

This block sits on the MAC side of a reduced media-independent link at 100 Mb/s. Every register in the block runs on one 50 MHz reference clock, and the RMII side transfers one di-bit in each clock cycle. The MAC side carries one nibble for every two clocks. On the transmit side, the bridge takes a nibble and its enable from the MAC and sends the nibble as two di-bits, low half first, with a qualifying transmit enable. On the receive side, it pairs incoming di-bits into nibbles. The first di-bit seen after the combined carrier/valid line rises is taken as the low half of the first nibble.

The combined receive line carries two signals, which the bridge separates. Carrier sense stops the first time the line is low on the first di-bit of a nibble. Data valid continues as long as the line is still high on the second di-bit of a nibble, so that slot still completes a nibble. A frame ends when the line is low on both slots of a nibble pair. The di-bits taken in that final pair are dropped. A nibble is marked as errored if the receive error input was high during either of its di-bits. The link has no collision wire, so the bridge raises a collision output whenever the recovered carrier and its own transmit enable are both high.

The transmit sequencer has three states. TX_IDLE goes to TX_LO when a nibble is offered and stays in TX_IDLE otherwise. TX_LO always goes to TX_HI. TX_HI goes to TX_LO when another nibble is offered and back to TX_IDLE when none is. The receive pairing machine has four states. RX_IDLE goes to RX_HI when the line is high. RX_HI always goes to RX_LO. RX_LO goes to RX_HI when the line is high and to RX_TAIL when it is low. RX_TAIL goes to RX_LO when the line is high and to RX_IDLE when it is low.

Top module: `rmii_mii_bridge`

## Requirements
- R1: While reset is asserted and after it is released, `rmii_tx_en`, `rmii_txd`, `mac_rx_stb`, `mac_rx_dv`, `mac_crs`, `mac_rx_er` and `mac_col` are 0 and `mac_tx_take` is 1.
- R2: `mac_tx_take` is high in every cycle except the cycle that drives the low di-bit of a nibble. During a frame it therefore alternates high and low.
- R3: If `mac_tx_take` and `mac_tx_en` are both high in a cycle, then in the next cycle `rmii_tx_en` is 1 and `rmii_txd` equals `mac_txd[1:0]`. In the cycle after that, `rmii_txd` equals `mac_txd[3:2]`.
- R4: Back-to-back nibbles leave no gap in `rmii_tx_en`. If `mac_tx_take` is high and `mac_tx_en` is low, then in the next cycle `rmii_tx_en` is 0 and `rmii_txd` is 0.
- R5: When `rmii_crs_dv` is high while the receiver is idle, that di-bit becomes bits 1:0 of the first nibble. In the cycle after the second di-bit, `mac_rx_stb` pulses with the assembled nibble on `mac_rxd`.
- R6: `mac_crs` and `mac_rx_dv` rise one cycle after `rmii_crs_dv` is first high. `mac_crs` falls one cycle after `rmii_crs_dv` is low on the first di-bit slot of a nibble, and it stays low for the rest of the frame.
- R7: If `rmii_crs_dv` is low on a first slot and high on the following second slot, that nibble is still delivered and `mac_rx_dv` stays high. If it is low on both slots, `mac_rx_dv` falls one cycle after the second slot and no nibble is delivered for that pair.
- R8: `mac_rx_er` delivered with a nibble is the OR of `rmii_rx_er` over that nibble's two di-bits.
- R9: `mac_col` is high exactly when `mac_crs` and `rmii_tx_en` are both high.
- R10: `mac_rx_stb` is never high in two consecutive cycles, and it is only high while `mac_rx_dv` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock for both directions |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_tx_en | input | 1 | The MAC is offering a nibble on `mac_txd` |
| mac_tx_take | output | 1 | The bridge samples `mac_txd` and `mac_tx_en` at the end of this cycle |
| rmii_txd | output | 2 | Transmit di-bit to the PHY |
| rmii_tx_en | output | 1 | Transmit di-bit valid |
| rmii_crs_dv | input | 1 | Combined carrier and receive-valid line from the PHY |
| rmii_rxd | input | 2 | Receive di-bit from the PHY |
| rmii_rx_er | input | 1 | Receive media error from the PHY |
| mac_rxd | output | 4 | Assembled receive nibble |
| mac_rx_stb | output | 1 | One-cycle pulse marking a new nibble on `mac_rxd` |
| mac_rx_er | output | 1 | Error flag for the nibble on `mac_rxd` |
| mac_rx_dv | output | 1 | A receive frame is in progress |
| mac_crs | output | 1 | Recovered carrier sense |
| mac_col | output | 1 | Collision indication |

## Verification
The transmit di-bits are due one and two cycles after the cycle in which a nibble is taken. Each receive indication (`mac_crs`, `mac_rx_dv`, `mac_rx_stb` with its nibble and error flag) is due one cycle after the di-bit slot that causes it. `mac_col` follows its two registered inputs in the same cycle. Each directed task drives a slot on a falling edge and checks on the next falling edge, so every check lands exactly one register stage after its stimulus. In the loopback scenario a monitor collects the delivered nibbles, and these are compared with the sent bytes, low nibble first, after the frame has drained.

// File: rtl/rmii_bridge_pkg.sv
package rmii_bridge_pkg;
    localparam int NIB_W = 4;
    localparam int DIB_W = 2;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LO   = 2'd1,
        TX_HI   = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HI   = 2'd1,
        RX_LO   = 2'd2,
        RX_TAIL = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rmii_tx_split.sv
module rmii_tx_split
    import rmii_bridge_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int DW = DIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] nib_in,
    input  logic          en_in,
    output logic          take,
    output logic [DW-1:0] dib_out,
    output logic          dib_en
);
    localparam int HI_TOP = NW - 1;

    tx_state_e     state_q, state_d;
    logic [NW-1:0] hold_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: state_d = en_in ? TX_LO : TX_IDLE;
            TX_LO:   state_d = TX_HI;
            TX_HI:   state_d = en_in ? TX_LO : TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    assign take = (state_q != TX_LO);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            dib_out <= '0;
            dib_en  <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE, TX_HI: begin
                    if (en_in) begin
                        hold_q  <= nib_in;
                        dib_out <= nib_in[DW-1:0];
                        dib_en  <= 1'b1;
                    end else begin
                        dib_out <= '0;
                        dib_en  <= 1'b0;
                    end
                end
                TX_LO:   dib_out <= hold_q[HI_TOP -: DW];
                default: dib_en  <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rmii_rx_merge.sv
module rmii_rx_merge
    import rmii_bridge_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int DW = DIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_act,
    input  logic [DW-1:0] dib_in,
    input  logic          dib_er,
    output logic [NW-1:0] nib_out,
    output logic          nib_stb,
    output logic          nib_er,
    output logic          frame_dv,
    output logic          carrier
);
    rx_state_e     state_q, state_d;
    logic [DW-1:0] low_q;
    logic          er_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: state_d = line_act ? RX_HI : RX_IDLE;
            RX_HI:   state_d = RX_LO;
            RX_LO:   state_d = line_act ? RX_HI : RX_TAIL;
            RX_TAIL: state_d = line_act ? RX_LO : RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q    <= '0;
            er_q     <= 1'b0;
            nib_out  <= '0;
            nib_stb  <= 1'b0;
            nib_er   <= 1'b0;
            frame_dv <= 1'b0;
            carrier  <= 1'b0;
        end else begin
            nib_stb <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    low_q    <= dib_in;
                    er_q     <= dib_er;
                    frame_dv <= line_act;
                    carrier  <= line_act;
                end
                RX_HI: begin
                    nib_out <= {dib_in, low_q};
                    nib_er  <= er_q | dib_er;
                    nib_stb <= 1'b1;
                end
                RX_LO: begin
                    low_q <= dib_in;
                    er_q  <= dib_er;
                    if (!line_act) carrier <= 1'b0;
                end
                RX_TAIL: begin
                    if (line_act) begin
                        nib_out <= {dib_in, low_q};
                        nib_er  <= er_q | dib_er;
                        nib_stb <= 1'b1;
                    end else begin
                        frame_dv <= 1'b0;
                    end
                end
                default: frame_dv <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rmii_col_gen.sv
module rmii_col_gen (
    input  logic carrier,
    input  logic tx_active,
    output logic col
);
    assign col = carrier & tx_active;
endmodule

// File: rtl/rmii_mii_bridge.sv
module rmii_mii_bridge
    import rmii_bridge_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int DW = DIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] mac_txd,
    input  logic          mac_tx_en,
    output logic          mac_tx_take,
    output logic [DW-1:0] rmii_txd,
    output logic          rmii_tx_en,
    input  logic          rmii_crs_dv,
    input  logic [DW-1:0] rmii_rxd,
    input  logic          rmii_rx_er,
    output logic [NW-1:0] mac_rxd,
    output logic          mac_rx_stb,
    output logic          mac_rx_er,
    output logic          mac_rx_dv,
    output logic          mac_crs,
    output logic          mac_col
);
    rmii_tx_split #(.NW(NW), .DW(DW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_in  (mac_txd),
        .en_in   (mac_tx_en),
        .take    (mac_tx_take),
        .dib_out (rmii_txd),
        .dib_en  (rmii_tx_en)
    );

    rmii_rx_merge #(.NW(NW), .DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_act (rmii_crs_dv),
        .dib_in   (rmii_rxd),
        .dib_er   (rmii_rx_er),
        .nib_out  (mac_rxd),
        .nib_stb  (mac_rx_stb),
        .nib_er   (mac_rx_er),
        .frame_dv (mac_rx_dv),
        .carrier  (mac_crs)
    );

    rmii_col_gen u_col (
        .carrier   (mac_crs),
        .tx_active (rmii_tx_en),
        .col       (mac_col)
    );
endmodule

// File: rtl/rmii_mii_bridge_chk.sv
module rmii_mii_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic mac_tx_en,
    input logic mac_tx_take,
    input logic rmii_tx_en,
    input logic rmii_crs_dv,
    input logic mac_rx_stb,
    input logic mac_rx_dv,
    input logic mac_crs,
    input logic mac_col
);
    a_r3_tx_start: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_tx_take && mac_tx_en) |=> rmii_tx_en);

    a_r2_take_alt: assert property (@(posedge clk) disable iff (!rst_n)
        (rmii_tx_en && !mac_tx_take) |=> (mac_tx_take && rmii_tx_en));

    a_r4_tx_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_tx_take && !mac_tx_en) |=> !rmii_tx_en);

    a_r6_crs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_rx_dv && rmii_crs_dv) |=> (mac_crs && mac_rx_dv));

    a_r6_crs_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mac_crs |-> mac_rx_dv);

    a_r10_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rx_stb |=> !mac_rx_stb);

    a_r10_stb_dv: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rx_stb |-> mac_rx_dv);

    a_r9_col_cause: assert property (@(posedge clk) disable iff (!rst_n)
        mac_col |-> (mac_crs && rmii_tx_en));

    a_r9_col_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_crs || !rmii_tx_en) |-> !mac_col);
endmodule

bind rmii_mii_bridge rmii_mii_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mac_tx_en   (mac_tx_en),
    .mac_tx_take (mac_tx_take),
    .rmii_tx_en  (rmii_tx_en),
    .rmii_crs_dv (rmii_crs_dv),
    .mac_rx_stb  (mac_rx_stb),
    .mac_rx_dv   (mac_rx_dv),
    .mac_crs     (mac_crs),
    .mac_col     (mac_col)
);

// File: tb/rmii_mii_bridge_test.sv
module rmii_mii_bridge_test;
    localparam int CLK_PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mac_txd = '0;
    logic       mac_tx_en = 1'b0;
    logic       mac_tx_take;
    logic [1:0] rmii_txd;
    logic       rmii_tx_en;
    logic       rmii_crs_dv;
    logic [1:0] rmii_rxd;
    logic       rmii_rx_er;
    logic [3:0] mac_rxd;
    logic       mac_rx_stb, mac_rx_er, mac_rx_dv, mac_crs, mac_col;

    logic       loop_q = 1'b0;
    logic       drv_crs = 1'b0;
    logic [1:0] drv_rxd = '0;
    logic       drv_er = 1'b0;

    assign rmii_crs_dv = loop_q ? rmii_tx_en : drv_crs;
    assign rmii_rxd    = loop_q ? rmii_txd   : drv_rxd;
    assign rmii_rx_er  = loop_q ? 1'b0       : drv_er;

    int n_cmp = 0;
    int n_bad = 0;
    int mon_cnt = 0;
    logic [3:0] mon_nib [64];
    logic col_seen = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmii_mii_bridge uut (.*);

    always @(negedge clk) begin
        if (mac_rx_stb) begin
            if (mon_cnt < 64) mon_nib[mon_cnt] = mac_rxd;
            mon_cnt = mon_cnt + 1;
        end
        if (mac_col) col_seen = 1'b1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        check("R1 tx_en", rmii_tx_en, 0);
        check("R1 txd", rmii_txd, 0);
        check("R1 take", mac_tx_take, 1);
        check("R1 rx_dv", mac_rx_dv, 0);
        check("R1 crs", mac_crs, 0);
        check("R1 stb", mac_rx_stb, 0);
        check("R1 rx_er", mac_rx_er, 0);
        check("R1 col", mac_col, 0);
    endtask

    // sends nbytes random bytes, low nibble first; checks R2 R3 R4 R9
    task automatic t_tx_frame(input int nbytes, input logic lp, output logic [3:0] sent [64]);
        loop_q = lp;
        @(negedge clk);
        check("R2 take idle", mac_tx_take, 1);
        for (int i = 0; i < 2*nbytes; i++) begin
            logic [3:0] n;
            n = 4'($urandom);
            sent[i] = n;
            mac_txd = n;
            mac_tx_en = 1'b1;
            @(negedge clk);
            check("R3 tx_en low slot", rmii_tx_en, 1);
            check("R3 low dibit", rmii_txd, n[1:0]);
            check("R2 take low", mac_tx_take, 0);
            @(negedge clk);
            check("R4 tx_en high slot", rmii_tx_en, 1);
            check("R3 high dibit", rmii_txd, n[3:2]);
            check("R2 take high", mac_tx_take, 1);
            check("R9 col during tx", mac_col, int'(lp));
        end
        mac_tx_en = 1'b0;
        mac_txd = '0;
        @(negedge clk);
        check("R4 tx_en end", rmii_tx_en, 0);
        check("R4 txd end", rmii_txd, 0);
        check("R9 col after tx", mac_col, 0);
        repeat (4) @(negedge clk);
        loop_q = 1'b0;
    endtask

    task automatic t_loopback();
        logic [3:0] sent [64];
        mon_cnt = 0;
        col_seen = 1'b0;
        t_tx_frame(6, 1'b1, sent);
        check("R5 loop nibble count", mon_cnt, 12);
        for (int i = 0; i < 12; i++) check("R5 loop nibble order", mon_nib[i], sent[i]);
        check("R9 loop col seen", col_seen, 1);
        check("R7 loop dv end", mac_rx_dv, 0);
    endtask

    task automatic t_tx_only();
        logic [3:0] sent [64];
        mon_cnt = 0;
        col_seen = 1'b0;
        t_tx_frame(3, 1'b0, sent);
        check("R9 no carrier no col", col_seen, 0);
        check("R5 no rx nibbles", mon_cnt, 0);
    endtask

    task automatic rx_slot(input logic c, input logic [1:0] d, input logic e);
        drv_crs = c;
        drv_rxd = d;
        drv_er = e;
        @(negedge clk);
    endtask

    // one nibble; lo_c is crs_dv on first slot, hi_c on second
    task automatic rx_nib(input logic [3:0] n, input logic lo_c, input logic hi_c,
                          input logic e0, input logic e1, input int crs_exp);
        rx_slot(lo_c, n[1:0], e0);
        check("R6 crs after first slot", mac_crs, crs_exp);
        check("R7 dv after first slot", mac_rx_dv, 1);
        check("R10 no stb mid nibble", mac_rx_stb, 0);
        rx_slot(hi_c, n[3:2], e1);
        check("R5 stb", mac_rx_stb, 1);
        check("R5 nibble", mac_rxd, n);
        check("R8 nibble error", mac_rx_er, int'(e0 | e1));
        check("R9 rx only col", mac_col, 0);
    endtask

    task automatic rx_end();
        rx_slot(1'b0, 2'b11, 1'b0);
        check("R6 crs end", mac_crs, 0);
        check("R7 dv held in pair", mac_rx_dv, 1);
        rx_slot(1'b0, 2'b10, 1'b0);
        check("R7 dv end", mac_rx_dv, 0);
        check("R7 tail dropped", mac_rx_stb, 0);
        rx_slot(1'b0, 2'b00, 1'b0);
        check("R10 idle no stb", mac_rx_stb, 0);
    endtask

    task automatic t_rx_basic();
        @(negedge clk);
        rx_nib(4'h5, 1, 1, 0, 0, 1);
        rx_nib(4'hA, 1, 1, 0, 0, 1);
        rx_nib(4'h3, 1, 1, 0, 0, 1);
        rx_nib(4'hE, 1, 1, 0, 0, 1);
        rx_end();
    endtask

    task automatic t_rx_toggle();
        rx_nib(4'h7, 1, 1, 0, 0, 1);
        rx_nib(4'hC, 1, 1, 0, 0, 1);
        rx_nib(4'h9, 0, 1, 0, 0, 0);
        rx_nib(4'h2, 0, 1, 0, 0, 0);
        rx_nib(4'hF, 1, 1, 0, 0, 0);
        rx_end();
    endtask

    task automatic t_rx_err();
        rx_nib(4'h1, 1, 1, 0, 0, 1);
        rx_nib(4'h6, 1, 1, 1, 0, 1);
        rx_nib(4'hB, 1, 1, 0, 1, 1);
        rx_nib(4'h4, 1, 1, 1, 1, 1);
        rx_nib(4'h8, 1, 1, 0, 0, 1);
        rx_end();
    endtask

    initial begin
        void'($urandom(32'd17));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_only();
        t_loopback();
        t_rx_basic();
        t_rx_toggle();
        t_rx_err();
        t_loopback();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule